// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block sits beside an SDRAM controller, or on a bus model in a testbench, and watches the command stream that reaches the memory. On every clock edge it decodes the four active-low command strobes and tracks the state of each bank, open or closed. It also runs down-counters that hold the minimum spacing still owed before a given command may legally reach that bank. A set of counters shared between banks covers the rules that span more than one bank. The burst length in use is supplied as an input, because the recovery and auto-precharge windows stretch with it.

Whenever a command breaks a spacing rule or reaches a bank in the wrong state, the monitor raises a one-cycle violation strobe and a three-bit code naming the rule. When several rules break in the same cycle, a fixed priority picks a single code. Every limit is a parameter counted in clock cycles. The monitor never blocks or alters the stream. A command that breaks a rule still updates the tracked state, so the state follows what the memory would actually do.

Top module: `sdram_cmd_timing_mon`

## Requirements
- R1: After reset the strobe is low and the code is 0. A no-operation {cs_n,ras_n,cas_n,we_n}=0111, or any cycle with cs_n high, never raises the strobe.
- R2: An activate (0011) to a bank that is already open, or a read (0101) or write (0100) to a closed bank, is reported with code 1.
- R3: A mode-register load (0000) or an auto-refresh (0001) issued while any bank is open or still precharging is reported with code 2. The bank address is ignored for both commands.
- R4: An activate to a bank fewer than T_RP cycles after that bank was precharged is reported with code 3. A precharge (0010) with the all-banks bit high closes every bank.
- R5: A read or write fewer than T_RCD cycles after the activate of its bank is reported with code 4.
- R6: An activate fewer than T_RRD cycles after an activate to a different bank is reported with code 5.
- R7: A precharge that closes a bank fewer than BL-1+T_WR cycles after a write to that bank is reported with code 6. The limit counts to the last data beat plus the recovery time.
- R8: A read or write fewer than T_CCD cycles after the previous read or write to any bank is reported with code 7.
- R9: A read with the auto-precharge bit set closes its bank. A later activate to that bank is legal from BL+T_RP cycles after the read and is reported with code 3 before that.
- R10: A write with the auto-precharge bit set closes its bank. A later activate to that bank is legal from BL-1+T_WR+T_RP cycles after the write and is reported with code 3 before that.
- R11: At most one code is reported per cycle, chosen in the order 1, 2, 3, 4, 5, 6, 7.
- R12: The strobe and code for a command are registered on the same rising edge that samples the command, and they last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the command bus |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_i | input | BA_W | Bank address of the command |
| ap_i | input | 1 | Auto-precharge bit on read/write; all-banks bit on precharge |
| burst_len_i | input | BL_W | Burst length in beats, 1 or more |
| viol_valid_o | output | 1 | Violation strobe |
| viol_code_o | output | 3 | Broken rule, 0 when none |

## Verification
Every verdict is registered from the command it judges. The strobe and code are therefore visible in the cycle after the edge that samples the command, and they return to zero one cycle later. The bench drives each command on a falling edge, waits for one rising edge, and reads the outputs on the following falling edge. Each spacing rule is exercised at the last illegal distance and at the first legal one. Distances are counted in whole cycles from the earlier command, so that for example R7 flags a precharge at distance BL-1+T_WR-1 and passes it at BL-1+T_WR.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_BST
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE  = 3'd0,
        V_STATE = 3'd1,
        V_IDLE  = 3'd2,
        V_RP    = 3'd3,
        V_RCD   = 3'd4,
        V_RRD   = 3'd5,
        V_WR    = 3'd6,
        V_CCD   = 3'd7
    } viol_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd_o
);

    always_comb begin
        if (cs_n) begin
            cmd_o = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = CMD_REF;
                3'b000:  cmd_o = CMD_MRS;
                3'b110:  cmd_o = CMD_BST;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_chk_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_WR  = 2,
    parameter int BL_W  = 4,
    parameter int CNT_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd_i,
    input  logic            hit_i,
    input  logic            ap_i,
    input  logic [BL_W-1:0] burst_len_i,
    output logic            err_state_o,
    output logic            err_rcd_o,
    output logic            err_rp_o,
    output logic            err_wr_o,
    output logic            busy_o
);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] rcd;
        logic [CNT_W-1:0] rp;
        logic [CNT_W-1:0] wr;
    } bank_st_t;

    localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);

    bank_st_t         st_d, st_q;
    logic             col;
    logic             pre_hit;
    logic [CNT_W-1:0] bl_ext;

    always_comb begin
        st_d    = st_q;
        bl_ext  = CNT_W'(burst_len_i);
        col     = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
        pre_hit = (cmd_i == CMD_PRE) && (hit_i || ap_i);

        if (st_q.rcd != '0) st_d.rcd = st_q.rcd - 1'b1;
        if (st_q.rp  != '0) st_d.rp  = st_q.rp  - 1'b1;
        if (st_q.wr  != '0) st_d.wr  = st_q.wr  - 1'b1;

        err_state_o = hit_i && (((cmd_i == CMD_ACT) && st_q.open) || (col && !st_q.open));
        err_rcd_o   = hit_i && col && st_q.open && (st_q.rcd != '0);
        err_rp_o    = hit_i && (cmd_i == CMD_ACT) && !st_q.open && (st_q.rp != '0);
        err_wr_o    = pre_hit && st_q.open && (st_q.wr != '0);
        busy_o      = st_q.open || (st_q.rp != '0);

        if (hit_i && (cmd_i == CMD_ACT)) begin
            st_d.open = 1'b1;
            st_d.rcd  = RCD_LD;
        end
        if (hit_i && (cmd_i == CMD_RD) && ap_i) begin
            st_d.open = 1'b0;
            st_d.rp   = bl_ext + CNT_W'(T_RP - 1);
        end
        if (hit_i && (cmd_i == CMD_WR)) begin
            st_d.wr = bl_ext + CNT_W'(T_WR - 2);
            if (ap_i) begin
                st_d.open = 1'b0;
                st_d.rp   = bl_ext + CNT_W'(T_WR + T_RP - 2);
            end
        end
        if (pre_hit && st_q.open) begin
            st_d.open = 1'b0;
            st_d.rp   = RP_LD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: an activate always leaves the bank open
    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && cmd_i == CMD_ACT) |=> st_q.open);

    // R4: a precharge, single or all, leaves the bank closed
    assert_pre_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == CMD_PRE) && (hit_i || ap_i)) |=> !st_q.open);

    // R9/R10: auto-precharge leaves the bank closed and busy
    assert_ap_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && col && ap_i && (cmd_i != CMD_ACT)) |=> (!st_q.open && busy_o));

endmodule

// File: rtl/sdram_cmd_timing_mon.sv
module sdram_cmd_timing_mon
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BL_W      = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 2,
    parameter int T_CCD     = 1,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] bank_i,
    input  logic            ap_i,
    input  logic [BL_W-1:0] burst_len_i,
    output logic            viol_valid_o,
    output logic [2:0]      viol_code_o
);

    localparam int MAX_LD = (2 ** BL_W) + T_WR + T_RP + T_RCD + T_RRD + T_CCD;
    localparam int CNT_W  = $clog2(MAX_LD + 1);

    typedef struct packed {
        logic [CNT_W-1:0] rrd;
        logic [CNT_W-1:0] ccd;
        logic [BA_W-1:0]  last_bank;
        logic             viol_valid;
        viol_e            viol_code;
    } top_st_t;

    top_st_t top_d, top_q;
    cmd_e    cmd;

    logic [NUM_BANKS-1:0] err_state, err_rcd, err_rp, err_wr, busy;
    logic                 is_act, is_col, rrd_err, ccd_err, idle_err;

    sdram_cmd_decode i_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd_o (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_track #(
            .T_RCD (T_RCD),
            .T_RP  (T_RP),
            .T_WR  (T_WR),
            .BL_W  (BL_W),
            .CNT_W (CNT_W)
        ) i_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_i       (cmd),
            .hit_i       (bank_i == BA_W'(b)),
            .ap_i        (ap_i),
            .burst_len_i (burst_len_i),
            .err_state_o (err_state[b]),
            .err_rcd_o   (err_rcd[b]),
            .err_rp_o    (err_rp[b]),
            .err_wr_o    (err_wr[b]),
            .busy_o      (busy[b])
        );
    end

    always_comb begin
        top_d    = top_q;
        is_act   = (cmd == CMD_ACT);
        is_col   = (cmd == CMD_RD) || (cmd == CMD_WR);

        if (top_q.rrd != '0) top_d.rrd = top_q.rrd - 1'b1;
        if (top_q.ccd != '0) top_d.ccd = top_q.ccd - 1'b1;

        rrd_err  = is_act && (bank_i != top_q.last_bank) && (top_q.rrd != '0);
        ccd_err  = is_col && (top_q.ccd != '0);
        idle_err = ((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|busy);

        if (is_act) begin
            top_d.rrd       = CNT_W'(T_RRD - 1);
            top_d.last_bank = bank_i;
        end
        if (is_col) top_d.ccd = CNT_W'(T_CCD - 1);

        if      (|err_state) top_d.viol_code = V_STATE;
        else if (idle_err)   top_d.viol_code = V_IDLE;
        else if (|err_rp)    top_d.viol_code = V_RP;
        else if (|err_rcd)   top_d.viol_code = V_RCD;
        else if (rrd_err)    top_d.viol_code = V_RRD;
        else if (|err_wr)    top_d.viol_code = V_WR;
        else if (ccd_err)    top_d.viol_code = V_CCD;
        else                 top_d.viol_code = V_NONE;
        top_d.viol_valid = (top_d.viol_code != V_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign viol_valid_o = top_q.viol_valid;
    assign viol_code_o  = top_q.viol_code;

    // R1: an idle command cycle never produces a violation
    assert_nop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) |=> !viol_valid_o);

    // R3: mode load or refresh with a busy bank is always reported
    assert_idle_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|busy)) |=> viol_valid_o);

    // R8: back-to-back column commands are reported when spacing exceeds one
    assert_ccd_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((T_CCD > 1) && is_col && $past(is_col)) |=> viol_valid_o);

    // R6: back-to-back activates to different banks are reported
    assert_rrd_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((T_RRD > 1) && is_act && $past(is_act) && (bank_i != $past(bank_i))) |=> viol_valid_o);

    // R11: the strobe and a nonzero code go together
    assert_single_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid_o == (viol_code_o != 3'd0));

endmodule

// File: tb/test_sdram_cmd_timing_mon.sv
module test_sdram_cmd_timing_mon;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_DSL = 4'b1000;

    // limits used: T_RCD=3 T_RP=3 T_RRD=2 T_WR=2 T_CCD=2, burst length 4
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] bank = 2'd0;
    logic       ap = 1'b0;
    logic [3:0] blen = 4'd4;
    logic       viol_valid;
    logic [2:0] viol_code;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    sdram_cmd_timing_mon #(
        .T_RCD (3), .T_RP (3), .T_RRD (2), .T_WR (2), .T_CCD (2)
    ) i_sdram_cmd_timing_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .bank_i       (bank),
        .ap_i         (ap),
        .burst_len_i  (blen),
        .viol_valid_o (viol_valid),
        .viol_code_o  (viol_code)
    );

    task automatic check_out(input logic [2:0] exp, input string tag);
        n_chk++;
        if (viol_valid !== (exp != 3'd0) || viol_code !== exp) begin
            n_fail++;
            $display("FAIL %s: valid=%0b code=%0d, expected valid=%0b code=%0d",
                     tag, viol_valid, viol_code, exp != 3'd0, exp);
        end
    endtask

    // drive at a falling edge, sample after the next rising edge
    task automatic do_cmd(input logic [3:0] c, input logic [1:0] b, input logic a,
                          input logic [2:0] exp, input string tag);
        {cs_n, ras_n, cas_n, we_n} = c;
        bank = b;
        ap   = a;
        @(posedge clk);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        ap = 1'b0;
        check_out(exp, tag);
    endtask

    task automatic nop(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check_out(3'd0, "R1 reset state");
        do_cmd(C_NOP, 2'd2, 1'b1, 3'd0, "R1 nop quiet");
        do_cmd(C_DSL, 2'd1, 1'b0, 3'd0, "R1 deselect quiet");
    endtask

    task automatic t_rcd();
        do_cmd(C_ACT, 2'd0, 1'b0, 3'd0, "R5 activate");
        nop(1);
        do_cmd(C_RD, 2'd0, 1'b0, 3'd4, "R5 read at distance 2");
        do_cmd(C_RD, 2'd0, 1'b0, 3'd7, "R8 read right after read");
        nop(1);
        do_cmd(C_WR, 2'd0, 1'b0, 3'd0, "R5 write at distance 5, R8 gap 2");
        nop(4);
        do_cmd(C_PRE, 2'd3, 1'b1, 3'd0, "R4 precharge all");
        nop(3);
    endtask

    task automatic t_state();
        do_cmd(C_RD, 2'd1, 1'b0, 3'd1, "R2 read to closed bank");
        do_cmd(C_ACT, 2'd1, 1'b0, 3'd0, "R2 activate closed bank");
        nop(2);
        do_cmd(C_ACT, 2'd1, 1'b0, 3'd1, "R2 activate open bank");
        nop(1);
        do_cmd(C_PRE, 2'd0, 1'b1, 3'd0, "R4 precharge all");
        nop(3);
    endtask

    task automatic t_write_rec();
        do_cmd(C_ACT, 2'd2, 1'b0, 3'd0, "R7 activate");
        nop(2);
        do_cmd(C_WR, 2'd2, 1'b0, 3'd0, "R7 write");
        do_cmd(C_WR, 2'd2, 1'b0, 3'd7, "R8 write right after write");
        nop(3);
        do_cmd(C_PRE, 2'd2, 1'b0, 3'd6, "R7 precharge at distance 4");
        nop(2);
        do_cmd(C_ACT, 2'd2, 1'b0, 3'd0, "R4 activate at distance 3");
        nop(2);
        do_cmd(C_WR, 2'd2, 1'b0, 3'd0, "R7 write again");
        nop(4);
        do_cmd(C_PRE, 2'd2, 1'b0, 3'd0, "R7 precharge at distance 5");
        nop(3);
    endtask

    task automatic t_rrd_rp();
        do_cmd(C_ACT, 2'd0, 1'b0, 3'd0, "R6 first activate");
        do_cmd(C_ACT, 2'd1, 1'b0, 3'd5, "R6 activate other bank at 1");
        nop(1);
        do_cmd(C_ACT, 2'd2, 1'b0, 3'd0, "R6 activate other bank at 2");
        do_cmd(C_PRE, 2'd0, 1'b1, 3'd0, "R4 precharge all");
        nop(2);
        do_cmd(C_ACT, 2'd0, 1'b0, 3'd0, "R4 activate at distance 3");
        do_cmd(C_RD, 2'd1, 1'b0, 3'd1, "R4 bank 1 closed by precharge all");
        do_cmd(C_PRE, 2'd0, 1'b1, 3'd0, "R4 precharge all again");
        nop(1);
        do_cmd(C_ACT, 2'd0, 1'b0, 3'd3, "R4 activate at distance 2");
        nop(2);
        do_cmd(C_PRE, 2'd0, 1'b1, 3'd0, "R4 precharge all");
        nop(3);
    endtask

    task automatic t_idle();
        do_cmd(C_ACT, 2'd0, 1'b0, 3'd0, "R3 activate");
        do_cmd(C_REF, 2'd2, 1'b0, 3'd2, "R3 refresh with bank 0 open");
        do_cmd(C_MRS, 2'd1, 1'b0, 3'd2, "R3 mode load with bank 0 open");
        nop(1);
        do_cmd(C_PRE, 2'd0, 1'b0, 3'd0, "R3 precharge");
        nop(1);
        do_cmd(C_REF, 2'd0, 1'b0, 3'd2, "R3 refresh while precharging");
        do_cmd(C_MRS, 2'd3, 1'b0, 3'd0, "R3 mode load all idle");
        do_cmd(C_REF, 2'd3, 1'b0, 3'd0, "R3 refresh all idle");
        nop(2);
    endtask

    task automatic t_read_ap();
        do_cmd(C_ACT, 2'd3, 1'b0, 3'd0, "R9 activate");
        nop(2);
        do_cmd(C_RD, 2'd3, 1'b1, 3'd0, "R9 read auto-precharge");
        do_cmd(C_RD, 2'd3, 1'b0, 3'd1, "R11 closed bank over spacing");
        nop(4);
        do_cmd(C_ACT, 2'd3, 1'b0, 3'd3, "R9 activate at distance 6");
        do_cmd(C_PRE, 2'd3, 1'b0, 3'd0, "R9 precharge");
        nop(2);
        do_cmd(C_ACT, 2'd3, 1'b0, 3'd0, "R9 reactivate");
        nop(2);
        do_cmd(C_RD, 2'd3, 1'b1, 3'd0, "R9 read auto-precharge again");
        nop(6);
        do_cmd(C_ACT, 2'd3, 1'b0, 3'd0, "R9 activate at distance 7");
        do_cmd(C_PRE, 2'd3, 1'b0, 3'd0, "R9 close");
        nop(3);
    endtask

    task automatic t_write_ap();
        do_cmd(C_ACT, 2'd1, 1'b0, 3'd0, "R10 activate");
        nop(2);
        do_cmd(C_WR, 2'd1, 1'b1, 3'd0, "R10 write auto-precharge");
        nop(6);
        do_cmd(C_ACT, 2'd1, 1'b0, 3'd3, "R10 activate at distance 7");
        do_cmd(C_PRE, 2'd1, 1'b0, 3'd0, "R10 precharge");
        nop(2);
        do_cmd(C_ACT, 2'd1, 1'b0, 3'd0, "R10 reactivate");
        nop(2);
        do_cmd(C_WR, 2'd1, 1'b1, 3'd0, "R10 write auto-precharge again");
        nop(7);
        do_cmd(C_ACT, 2'd1, 1'b0, 3'd0, "R10 activate at distance 8");
    endtask

    task automatic t_timing();
        // R12: a flagged cycle is followed by a clean one
        do_cmd(C_ACT, 2'd1, 1'b0, 3'd1, "R12 flagged activate");
        check_out(3'd1, "R12 code held until next edge");
        nop(1);
        check_out(3'd0, "R12 strobe lasts one cycle");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: valid=%0b code=%0d, expected run to end", viol_valid, viol_code);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rcd();
        t_state();
        t_write_rec();
        t_rrd_rp();
        t_idle();
        t_read_ap();
        t_write_ap();
        t_timing();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule